// File: doc/BRIEF.md
# Load-Use Stall Detection Unit

This block sits between the decode and execute stages of a five-stage in-order pipeline. It detects one specific hazard: the instruction in execute is a memory load, and the instruction now in decode reads the register that the load will write. Forwarding cannot help here, because the loaded value exists only after the memory stage. The block is purely combinational. It compares the register numbers of the two stages and, when the hazard is present, holds the front of the pipeline for one cycle and sends an empty operation into execute.

When it stalls, the block clears the program-counter write enable and the fetch/decode register write enable. The instruction in decode is then decoded again and the instruction behind it is fetched again, and both repeats do no harm. At the same moment the block switches its built-in bubble multiplexer so that the control word entering execute is all zeros. That empty operation changes nothing in the execute, memory or write-back stages. One cycle later the load sits in memory, the bubble sits in execute, and the dependent instruction picks up the loaded value through the existing write-back forwarding path.

Top module: `load_use_hazard`

## Requirements
- R1: With the execute-stage memory-read flag at 1 and a non-zero execute destination equal to the first decode source, the block stalls (bubble_sel = 1).
- R2: With the execute-stage memory-read flag at 1 and a non-zero execute destination equal to the second decode source, the block stalls.
- R3: With the execute-stage memory-read flag at 0, the block never stalls, even when the register numbers match.
- R4: A load whose destination is register 0 never causes a stall.
- R5: While stalling, pc_wr_en and fd_wr_en are both 0.
- R6: When not stalling, pc_wr_en and fd_wr_en are both 1, bubble_sel is 0, and ctl_out equals ctl_in bit for bit.
- R7: While stalling, ctl_out is all zeros whatever ctl_in holds.
- R8: A stall lasts one cycle. Bit 0 of the control word is the memory-read flag. Once the zeroed word reaches execute, the held dependent instruction no longer stalls.
- R9: A load followed by an instruction that reads neither of the load's destinations causes no stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dec_src_a | input | REG_W | First source register number of the decode-stage instruction |
| dec_src_b | input | REG_W | Second source register number of the decode-stage instruction |
| ex_dst | input | REG_W | Load destination register number of the execute-stage instruction |
| ex_mem_rd | input | 1 | Execute-stage instruction reads memory |
| ctl_in | input | CTL_W | Control word produced by decode for the next execute stage |
| pc_wr_en | output | 1 | Program counter may update |
| fd_wr_en | output | 1 | Fetch/decode pipeline register may update |
| bubble_sel | output | 1 | Selects the all-zero control word into execute |
| ctl_out | output | CTL_W | Control word passed on toward execute |

## Verification
The assertions assume that every input has settled and is free of X before an output is checked. They also assume that the memory-read flag reaching this block comes from the same control word format that the bubble multiplexer clears, so a bubble can never look like a load. The bench changes inputs only on the falling clock edge and checks on the rising edge. To follow the R8 sequence it feeds bit 0 of the zeroed control word back as the next execute memory-read flag, the same way the real execute register would. Every register number it drives fits within REG_W bits.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    localparam int REG_W_DEF = 5;
    localparam int CTL_W_DEF = 9;
    localparam int NUM_SRC   = 2;

    typedef struct packed {
        logic stall;
        logic pc_we;
        logic fd_we;
        logic bub;
    } hz_dec_t;

    function automatic logic load_can_block(input logic mem_rd,
                                            input logic dst_zero,
                                            input logic skip_zero);
        return mem_rd && !(skip_zero && dst_zero);
    endfunction

endpackage

// File: rtl/hzd_src_cmp.sv
module hzd_src_cmp #(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0][REG_W-1:0] srcs,
    input  logic [REG_W-1:0]              dst,
    output logic [NUM_SRC-1:0]            hit,
    output logic                          dst_zero
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_cmp
        assign hit[i] = (srcs[i] == dst);
    end

    assign dst_zero = (dst == '0);
endmodule

// File: rtl/hzd_stall_ctl.sv
module hzd_stall_ctl
    import hzd_pkg::*;
#(
    parameter int NUM_SRC   = 2,
    parameter bit SKIP_ZERO = 1'b1
) (
    input  logic [NUM_SRC-1:0] hit,
    input  logic               mem_rd,
    input  logic               dst_zero,
    output hz_dec_t            dec
);
    logic live;

    if (SKIP_ZERO) begin : g_skip
        assign live = load_can_block(mem_rd, dst_zero, 1'b1);
    end else begin : g_noskip
        assign live = load_can_block(mem_rd, dst_zero, 1'b0);
    end

    always_comb begin
        dec.stall = live && (|hit);
        dec.pc_we = !dec.stall;
        dec.fd_we = !dec.stall;
        dec.bub   = dec.stall;
    end
endmodule

// File: rtl/hzd_bubble_mux.sv
module hzd_bubble_mux #(
    parameter int CTL_W = 9
) (
    input  logic             bub,
    input  logic [CTL_W-1:0] ctl_in,
    output logic [CTL_W-1:0] ctl_out
);
    assign ctl_out = bub ? '0 : ctl_in;
endmodule

// File: rtl/load_use_hazard.sv
module load_use_hazard
    import hzd_pkg::*;
#(
    parameter int REG_W     = REG_W_DEF,
    parameter int CTL_W     = CTL_W_DEF,
    parameter bit SKIP_ZERO = 1'b1
) (
    input  logic [REG_W-1:0] dec_src_a,
    input  logic [REG_W-1:0] dec_src_b,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             ex_mem_rd,
    input  logic [CTL_W-1:0] ctl_in,
    output logic             pc_wr_en,
    output logic             fd_wr_en,
    output logic             bubble_sel,
    output logic [CTL_W-1:0] ctl_out
);
    logic [NUM_SRC-1:0][REG_W-1:0] srcs;
    logic [NUM_SRC-1:0]            hit;
    logic                          dst_zero;
    hz_dec_t                       dec;

    assign srcs[0] = dec_src_a;
    assign srcs[1] = dec_src_b;

    hzd_src_cmp #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_cmp (
        .srcs     (srcs),
        .dst      (ex_dst),
        .hit      (hit),
        .dst_zero (dst_zero)
    );

    hzd_stall_ctl #(.NUM_SRC(NUM_SRC), .SKIP_ZERO(SKIP_ZERO)) u_ctl (
        .hit      (hit),
        .mem_rd   (ex_mem_rd),
        .dst_zero (dst_zero),
        .dec      (dec)
    );

    hzd_bubble_mux #(.CTL_W(CTL_W)) u_mux (
        .bub     (dec.bub),
        .ctl_in  (ctl_in),
        .ctl_out (ctl_out)
    );

    assign pc_wr_en   = dec.pc_we;
    assign fd_wr_en   = dec.fd_we;
    assign bubble_sel = dec.bub;

    always_comb begin
        p_no_load_no_stall_r3: assert (ex_mem_rd || !bubble_sel)
            else $error("R3: stall without a load in execute");
        if (SKIP_ZERO) begin
            p_zero_dst_free_r4: assert (ex_dst != '0 || !bubble_sel)
                else $error("R4: stall on register 0");
        end
        p_freeze_pair_r5: assert (pc_wr_en == fd_wr_en && pc_wr_en == !bubble_sel)
            else $error("R5: write enables disagree with bubble select");
        p_pass_through_r6: assert (bubble_sel || ctl_out == ctl_in)
            else $error("R6: control word altered without stall");
        p_bubble_clears_r7: assert (!bubble_sel || ctl_out == '0)
            else $error("R7: bubble word not zero");
        p_match_needed_r1: assert (!bubble_sel || ex_dst == dec_src_a || ex_dst == dec_src_b)
            else $error("R1: stall without a register match");
    end
endmodule

// File: tb/load_use_hazard_tb.sv
module load_use_hazard_tb;
    localparam int REG_W = 5;
    localparam int CTL_W = 9;

    typedef struct {
        string            req;
        logic             pc;
        logic             fd;
        logic             bub;
        logic [CTL_W-1:0] ctl;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [REG_W-1:0] dec_src_a = '0, dec_src_b = '0, ex_dst = '0;
    logic             ex_mem_rd = 1'b0;
    logic [CTL_W-1:0] ctl_in = '0;
    logic             pc_wr_en, fd_wr_en, bubble_sel;
    logic [CTL_W-1:0] ctl_out;

    load_use_hazard #(.REG_W(REG_W), .CTL_W(CTL_W)) u_dut (
        .dec_src_a (dec_src_a),
        .dec_src_b (dec_src_b),
        .ex_dst    (ex_dst),
        .ex_mem_rd (ex_mem_rd),
        .ctl_in    (ctl_in),
        .pc_wr_en  (pc_wr_en),
        .fd_wr_en  (fd_wr_en),
        .bubble_sel(bubble_sel),
        .ctl_out   (ctl_out)
    );

    exp_t q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;
    logic last_mrd_out;

    task automatic drive(string req, logic [REG_W-1:0] a, logic [REG_W-1:0] b,
                         logic [REG_W-1:0] d, logic mrd, logic [CTL_W-1:0] c);
        exp_t e;
        logic st;
        @(negedge clk);
        dec_src_a = a; dec_src_b = b; ex_dst = d; ex_mem_rd = mrd; ctl_in = c;
        st = mrd && (d != 0) && (d == a || d == b);
        e.req = req;
        e.pc  = !st;
        e.fd  = !st;
        e.bub = st;
        e.ctl = st ? '0 : c;
        last_mrd_out = e.ctl[0];
        q.push_back(e);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            if (q.size() != 0) begin
                exp_t e;
                e = q.pop_front();
                n_run++;
                if (pc_wr_en !== e.pc || fd_wr_en !== e.fd ||
                    bubble_sel !== e.bub || ctl_out !== e.ctl) begin
                    n_fail++;
                    $display("FAIL %s: got pc=%b fd=%b bub=%b ctl=%h, expected pc=%b fd=%b bub=%b ctl=%h",
                             e.req, pc_wr_en, fd_wr_en, bubble_sel, ctl_out,
                             e.pc, e.fd, e.bub, e.ctl);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : stimulus
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Reset / idle state: nothing in flight, R6
        drive("R6_idle", 5'd0, 5'd0, 5'd0, 1'b0, 9'h000);
        // R1: load dst matches first source
        drive("R1", 5'd8, 5'd3, 5'd8, 1'b1, 9'h1a5);
        // R2: load dst matches second source
        drive("R2", 5'd4, 5'd17, 5'd17, 1'b1, 9'h0ff);
        // R1 / R2 both match
        drive("R1_R2_both", 5'd9, 5'd9, 5'd9, 1'b1, 9'h1ff);
        // R3: match but no memory read
        drive("R3", 5'd12, 5'd6, 5'd12, 1'b0, 9'h0c3);
        drive("R3_b", 5'd1, 5'd31, 5'd31, 1'b0, 9'h1fe);
        // R4: load into register 0 with zero sources
        drive("R4", 5'd0, 5'd0, 5'd0, 1'b1, 9'h155);
        drive("R4_b", 5'd0, 5'd7, 5'd0, 1'b1, 9'h0aa);
        // R9: independent instruction after load
        drive("R9", 5'd2, 5'd3, 5'd10, 1'b1, 9'h101);
        drive("R9_b", 5'd30, 5'd29, 5'd31, 1'b1, 9'h0f1);
        // R5 / R7: stall with full control word
        drive("R5_R7", 5'd31, 5'd5, 5'd31, 1'b1, 9'h1ff);
        // R8: stall, then bubble reaches execute with zeroed memory-read bit
        drive("R8_stall", 5'd14, 5'd15, 5'd15, 1'b1, 9'h001);
        drive("R8_after", 5'd14, 5'd15, 5'd15, last_mrd_out, 9'h001);
        // R6: pass-through patterns
        drive("R6_a", 5'd5, 5'd6, 5'd7, 1'b1, 9'h0a5);
        drive("R6_b", 5'd5, 5'd6, 5'd5, 1'b0, 9'h15a);
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule